// File: doc/BRIEF.md
# Low-Power Mode Entry and Exit Sequencer

This block sits next to a processor core and decides when the core may stop clocking and how deep that stop goes. It takes three kinds of request pulse: wait-for-interrupt, wait-for-event, and return from an exception handler. It also takes a set of control levels and the pending status of interrupts and events. From these it chooses one of two modes. In a light sleep only the core clock is gated. In a deep stop the whole domain clock is gated, the PLL and oscillator are turned off, flash can be powered down, and the regulator can drop to low-power operation. Register and memory contents are kept in both modes because only clocks are removed.

The signal that wakes the core depends on how the mode was entered. An entry by wait-for-interrupt or by exception return wakes on any enabled pending interrupt. An entry by wait-for-event wakes on a wakeup event. If send-on-pending was set when the core entered, any pending interrupt also wakes it, including one that is masked at the interrupt controller. Leaving sleep takes no extra cycles. Leaving stop first turns the oscillator and PLL back on and waits for the oscillator and regulator to report ready. If flash was powered down, the block then counts a fixed flash startup delay before it releases the core.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in run: mode = 0 (0 run, 1 sleep, 2 stop), and coreClkEn, domainClkEn, pllEn and oscEn are 1, while flashPd and regLowPower are 0.
- R2: In run, a wfiReq pulse with irqPending = 0 enters a low-power mode on the next clock edge. With irqPending = 1 it is ignored and mode stays 0.
- R3: In run, a wfeReq pulse enters a low-power mode only when wakeEvent = 0. A pending interrupt does not block this entry.
- R4: In run, an isrReturn pulse enters a low-power mode only when sleepOnExit = 1 and irqPending = 0. Otherwise it is ignored.
- R5: When several requests qualify in the same cycle, wfiReq wins over wfeReq, and wfeReq wins over isrReturn. The winner sets the wake rule.
- R6: After an entry by wfiReq or isrReturn, irqPending = 1 wakes the core. wakeEvent alone does not.
- R7: After an entry by wfeReq with sevOnPend = 0 at the request, only wakeEvent wakes the core. irqPending and irqPendingAny have no effect.
- R8: After an entry by wfeReq with sevOnPend = 1 at the request, either irqPendingAny or wakeEvent wakes the core.
- R9: In sleep, coreClkEn = 0 while domainClkEn, pllEn and oscEn stay 1. A wake source seen at a clock edge gives coreClkEn = 1 and mode = 0 right after that edge.
- R10: An entry with deepSleep = 1 gives stop (mode 2). In stop, coreClkEn, domainClkEn, pllEn and oscEn are all 0. flashPd and regLowPower take the values that flashPdEn and regLpSel had at the request.
- R11: A wake source in stop sets oscEn = 1, pllEn = 1 and regLowPower = 0 at the next edge. The clocks stay gated (mode 2) until oscReady and regReady are both 1 at the same edge.
- R12: If flashPd was latched, the edge that sees both ready inputs clears flashPd and starts the delay. coreClkEn rises FLASH_DELAY edges later. Without flashPd, coreClkEn rises at the edge that sees both ready inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wfiReq | input | 1 | Wait-for-interrupt request pulse |
| wfeReq | input | 1 | Wait-for-event request pulse |
| isrReturn | input | 1 | Exception return pulse |
| deepSleep | input | 1 | Selects stop instead of sleep |
| sleepOnExit | input | 1 | Allows entry on exception return |
| sevOnPend | input | 1 | Lets pending interrupts count as events after a wfe entry |
| flashPdEn | input | 1 | Powers down flash during stop |
| regLpSel | input | 1 | Selects low-power regulator during stop |
| irqPending | input | 1 | An enabled interrupt is pending |
| irqPendingAny | input | 1 | Any interrupt is pending, masked or not |
| wakeEvent | input | 1 | Wakeup event present |
| oscReady | input | 1 | Oscillator stable |
| regReady | input | 1 | Regulator back in normal mode |
| coreClkEn | output | 1 | Core clock gate enable |
| domainClkEn | output | 1 | Domain clock gate enable |
| pllEn | output | 1 | PLL enable |
| oscEn | output | 1 | Oscillator enable |
| flashPd | output | 1 | Flash power-down |
| regLowPower | output | 1 | Regulator low-power mode |
| mode | output | 2 | 0 run, 1 sleep, 2 stop (including the wake-up phases) |

## Verification
The bench builds the sequencer with FLASH_DELAY = 5. This keeps the flash wait short enough to walk one cycle at a time, so the bench can check that the core stays gated before the release edge and opens exactly on it. The same value also exercises the loaded counter down to zero without reaching the single-cycle case that FLASH_DELAY = 1 would give. Each wake rule is paired with a source that must not wake the core, so the rule latched at entry is seen at the ports.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STOP,
    ST_WAKE_OSC,
    ST_WAKE_FLASH
  } pwrState_e;

  typedef enum logic [1:0] {
    WK_IRQ,
    WK_EVT,
    WK_EVT_OR_PEND
  } wakeKind_e;

  typedef struct packed {
    logic captureCfg;
    logic loadDelay;
    logic tickDelay;
  } ctrlStrobe_t;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_STOP  = 2'd2;

endpackage

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wfiReq,
  input  logic        wfeReq,
  input  logic        isrReturn,
  input  logic        deepSleep,
  input  logic        sleepOnExit,
  input  logic        sevOnPend,
  input  logic        irqPending,
  input  logic        irqPendingAny,
  input  logic        wakeEvent,
  input  logic        oscReady,
  input  logic        regReady,
  input  logic        cfgFlashPd,
  input  logic        delayDone,
  output pwrState_e   nextState,
  output ctrlStrobe_t strobe
);

  pwrState_e state;
  wakeKind_e wakeKind, wakeKindNext;
  logic      entering;
  logic      wakeHit;

  // wake rule chosen at entry
  always_comb begin
    unique case (wakeKind)
      WK_IRQ:         wakeHit = irqPending;
      WK_EVT:         wakeHit = wakeEvent;
      WK_EVT_OR_PEND: wakeHit = wakeEvent | irqPendingAny;
      default:        wakeHit = 1'b0;
    endcase
  end

  always_comb begin
    nextState    = state;
    strobe       = '0;
    wakeKindNext = wakeKind;
    entering     = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (wfiReq && !irqPending) begin
          entering     = 1'b1;
          wakeKindNext = WK_IRQ;
        end else if (wfeReq && !wakeEvent) begin
          entering     = 1'b1;
          wakeKindNext = sevOnPend ? WK_EVT_OR_PEND : WK_EVT;
        end else if (isrReturn && sleepOnExit && !irqPending) begin
          entering     = 1'b1;
          wakeKindNext = WK_IRQ;
        end
        if (entering) begin
          nextState         = deepSleep ? ST_STOP : ST_SLEEP;
          strobe.captureCfg = deepSleep;
        end
      end
      ST_SLEEP: begin
        if (wakeHit) nextState = ST_RUN;
      end
      ST_STOP: begin
        if (wakeHit) nextState = ST_WAKE_OSC;
      end
      ST_WAKE_OSC: begin
        if (oscReady && regReady) begin
          if (cfgFlashPd) begin
            nextState        = ST_WAKE_FLASH;
            strobe.loadDelay = 1'b1;
          end else begin
            nextState = ST_RUN;
          end
        end
      end
      ST_WAKE_FLASH: begin
        if (delayDone) nextState = ST_RUN;
        else           strobe.tickDelay = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      wakeKind <= WK_IRQ;
    end else begin
      state    <= nextState;
      wakeKind <= wakeKindNext;
    end
  end

  // R6: interrupt-rule sleep always leaves on a pending interrupt
  a_r6_irq_wakes: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && wakeKind == WK_IRQ && irqPending) |=> state == ST_RUN);

  // R7: event-only rule ignores interrupts
  a_r7_event_only: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && wakeKind == WK_EVT && !wakeEvent) |=> state == ST_SLEEP);

  // R11: no progress out of oscillator wait until both readies
  a_r11_wait_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE_OSC && !(oscReady && regReady)) |=> state == ST_WAKE_OSC);

  // R12: flash wait never skips straight from stop
  a_r12_flash_after_osc: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |=> state != ST_WAKE_FLASH);

endmodule

// File: rtl/pwr_mode_datapath.sv
module pwr_mode_datapath
  import pwr_mode_pkg::*;
#(
  parameter int FLASH_DELAY = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  pwrState_e   nextState,
  input  ctrlStrobe_t strobe,
  input  logic        flashPdEn,
  input  logic        regLpSel,
  output logic        cfgFlashPd,
  output logic        delayDone,
  output logic        coreClkEn,
  output logic        domainClkEn,
  output logic        pllEn,
  output logic        oscEn,
  output logic        flashPd,
  output logic        regLowPower,
  output logic [1:0]  mode
);

  localparam int CNT_W = (FLASH_DELAY > 1) ? $clog2(FLASH_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FLASH_DELAY - 1);

  logic [CNT_W-1:0] delayCnt;
  logic             cfgRegLp;
  logic             flashPdNext, regLpNext;
  logic             coreN, domN, pllN, oscN, fpdN, rlpN;
  logic [1:0]       modeN;

  // configuration captured at stop entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFlashPd <= 1'b0;
      cfgRegLp   <= 1'b0;
    end else if (strobe.captureCfg) begin
      cfgFlashPd <= flashPdEn;
      cfgRegLp   <= regLpSel;
    end
  end

  assign flashPdNext = strobe.captureCfg ? flashPdEn : cfgFlashPd;
  assign regLpNext   = strobe.captureCfg ? regLpSel  : cfgRegLp;

  // flash startup down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 delayCnt <= '0;
    else if (strobe.loadDelay) delayCnt <= CNT_LOAD;
    else if (strobe.tickDelay) delayCnt <= delayCnt - 1'b1;
  end

  assign delayDone = (delayCnt == '0);

  // gate plan for the state about to be entered
  always_comb begin
    unique case (nextState)
      ST_RUN:        {coreN, domN, pllN, oscN, fpdN, rlpN, modeN} =
                     {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, MODE_RUN};
      ST_SLEEP:      {coreN, domN, pllN, oscN, fpdN, rlpN, modeN} =
                     {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, MODE_SLEEP};
      ST_STOP:       {coreN, domN, pllN, oscN, fpdN, rlpN, modeN} =
                     {1'b0, 1'b0, 1'b0, 1'b0, flashPdNext, regLpNext, MODE_STOP};
      ST_WAKE_OSC:   {coreN, domN, pllN, oscN, fpdN, rlpN, modeN} =
                     {1'b0, 1'b0, 1'b1, 1'b1, flashPdNext, 1'b0, MODE_STOP};
      ST_WAKE_FLASH: {coreN, domN, pllN, oscN, fpdN, rlpN, modeN} =
                     {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, MODE_STOP};
      default:       {coreN, domN, pllN, oscN, fpdN, rlpN, modeN} =
                     {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, MODE_RUN};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreClkEn   <= 1'b1;
      domainClkEn <= 1'b1;
      pllEn       <= 1'b1;
      oscEn       <= 1'b1;
      flashPd     <= 1'b0;
      regLowPower <= 1'b0;
      mode        <= MODE_RUN;
    end else begin
      coreClkEn   <= coreN;
      domainClkEn <= domN;
      pllEn       <= pllN;
      oscEn       <= oscN;
      flashPd     <= fpdN;
      regLowPower <= rlpN;
      mode        <= modeN;
    end
  end

  // R12: counter stays inside its loaded range
  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    delayCnt <= CNT_LOAD);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int FLASH_DELAY = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfiReq,
  input  logic       wfeReq,
  input  logic       isrReturn,
  input  logic       deepSleep,
  input  logic       sleepOnExit,
  input  logic       sevOnPend,
  input  logic       flashPdEn,
  input  logic       regLpSel,
  input  logic       irqPending,
  input  logic       irqPendingAny,
  input  logic       wakeEvent,
  input  logic       oscReady,
  input  logic       regReady,
  output logic       coreClkEn,
  output logic       domainClkEn,
  output logic       pllEn,
  output logic       oscEn,
  output logic       flashPd,
  output logic       regLowPower,
  output logic [1:0] mode
);

  pwrState_e   nextState;
  ctrlStrobe_t strobe;
  logic        cfgFlashPd;
  logic        delayDone;

  pwr_mode_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wfiReq       (wfiReq),
    .wfeReq       (wfeReq),
    .isrReturn    (isrReturn),
    .deepSleep    (deepSleep),
    .sleepOnExit  (sleepOnExit),
    .sevOnPend    (sevOnPend),
    .irqPending   (irqPending),
    .irqPendingAny(irqPendingAny),
    .wakeEvent    (wakeEvent),
    .oscReady     (oscReady),
    .regReady     (regReady),
    .cfgFlashPd   (cfgFlashPd),
    .delayDone    (delayDone),
    .nextState    (nextState),
    .strobe       (strobe)
  );

  pwr_mode_datapath #(.FLASH_DELAY(FLASH_DELAY)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .nextState  (nextState),
    .strobe     (strobe),
    .flashPdEn  (flashPdEn),
    .regLpSel   (regLpSel),
    .cfgFlashPd (cfgFlashPd),
    .delayDone  (delayDone),
    .coreClkEn  (coreClkEn),
    .domainClkEn(domainClkEn),
    .pllEn      (pllEn),
    .oscEn      (oscEn),
    .flashPd    (flashPd),
    .regLowPower(regLowPower),
    .mode       (mode)
  );

  // R9: a low-power mode never runs the core clock
  a_r9_core_gated: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_RUN) |-> !coreClkEn);

  // R2: blocked wait-for-interrupt leaves run untouched
  a_r2_wfi_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RUN && wfiReq && irqPending && !wfeReq && !isrReturn) |=> mode == MODE_RUN);

  // R10: stop with oscillator off has every clock source off
  a_r10_stop_dark: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STOP && !oscEn) |-> (!pllEn && !domainClkEn));

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  localparam int FD = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfiReq = 0, wfeReq = 0, isrReturn = 0;
  logic deepSleep = 0, sleepOnExit = 0, sevOnPend = 0, flashPdEn = 0, regLpSel = 0;
  logic irqPending = 0, irqPendingAny = 0, wakeEvent = 0, oscReady = 0, regReady = 0;
  logic coreClkEn, domainClkEn, pllEn, oscEn, flashPd, regLowPower;
  logic [1:0] mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.FLASH_DELAY(FD)) u_dut (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .wfeReq(wfeReq), .isrReturn(isrReturn),
    .deepSleep(deepSleep), .sleepOnExit(sleepOnExit), .sevOnPend(sevOnPend),
    .flashPdEn(flashPdEn), .regLpSel(regLpSel), .irqPending(irqPending),
    .irqPendingAny(irqPendingAny), .wakeEvent(wakeEvent), .oscReady(oscReady),
    .regReady(regReady), .coreClkEn(coreClkEn), .domainClkEn(domainClkEn),
    .pllEn(pllEn), .oscEn(oscEn), .flashPd(flashPd), .regLowPower(regLowPower),
    .mode(mode)
  );

  // fields: kind[10:9] (0 wfi,1 wfe,2 isr) sev[8] soe[7] pendIrq[6] pendEvt[5]
  //         stimIrq[4] stimAny[3] stimEvt[2] expEnter[1] expWake[0]
  localparam logic [10:0] VECS [0:12] = '{
    11'b00_0_0_00_100_11, // R2 R6 R9 wfi, wake on irq
    11'b00_0_0_10_000_00, // R2 wfi blocked by pending irq
    11'b00_0_0_00_001_10, // R6 wfi, event does not wake
    11'b01_0_0_00_001_11, // R3 R7 wfe, event wakes
    11'b01_0_0_01_000_00, // R3 wfe blocked by event
    11'b01_0_0_00_110_10, // R7 wfe sev0, interrupts ignored
    11'b01_1_0_00_010_11, // R8 wfe sev1, masked pending wakes
    11'b01_1_0_00_001_11, // R8 wfe sev1, event wakes
    11'b10_0_1_00_100_11, // R4 isr return, irq wakes
    11'b10_0_0_00_000_00, // R4 sleep-on-exit off
    11'b10_0_1_10_000_00, // R4 blocked by pending irq
    11'b10_0_1_00_001_10, // R6 isr entry ignores event
    11'b01_0_0_10_001_11  // R3 pending irq does not block wfe
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wakeAll();
    irqPending = 1; irqPendingAny = 1; wakeEvent = 1;
    tick();
    irqPending = 0; irqPendingAny = 0; wakeEvent = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    check("R1 mode", {6'd0, mode}, 8'd0);
    check("R1 gates", {4'd0, coreClkEn, domainClkEn, pllEn, oscEn}, 8'hF);
    check("R1 flashPd/regLp", {6'd0, flashPd, regLowPower}, 8'd0);

    // table walk, sleep mode only
    for (int i = 0; i < 13; i++) begin
      logic [10:0] v;
      v = VECS[i];
      sevOnPend = v[8]; sleepOnExit = v[7];
      irqPending = v[6]; wakeEvent = v[5];
      wfiReq = (v[10:9] == 2'd0); wfeReq = (v[10:9] == 2'd1); isrReturn = (v[10:9] == 2'd2);
      tick();
      wfiReq = 0; wfeReq = 0; isrReturn = 0; irqPending = 0; wakeEvent = 0;
      check($sformatf("R2/R3/R4 entry vector %0d", i), {6'd0, mode}, v[1] ? 8'd1 : 8'd0);
      if (v[1]) begin
        check($sformatf("R9 sleep gates vector %0d", i),
              {4'd0, coreClkEn, domainClkEn, pllEn, oscEn}, 8'h7);
        irqPending = v[4]; irqPendingAny = v[3]; wakeEvent = v[2];
        tick();
        irqPending = 0; irqPendingAny = 0; wakeEvent = 0;
        check($sformatf("R6/R7/R8 wake vector %0d", i), {6'd0, mode}, v[0] ? 8'd0 : 8'd1);
        check($sformatf("R9 core clock vector %0d", i), {7'd0, coreClkEn}, {7'd0, v[0]});
        if (!v[0]) begin
          wakeAll();
          check($sformatf("R9 cleanup vector %0d", i), {6'd0, mode}, 8'd0);
        end
      end
      sevOnPend = 0; sleepOnExit = 0;
      tick();
    end

    // R5 wfi beats wfe: rule is interrupt, so event does not wake
    wfiReq = 1; wfeReq = 1;
    tick();
    wfiReq = 0; wfeReq = 0;
    wakeEvent = 1;
    tick();
    wakeEvent = 0;
    check("R5 wfi over wfe", {6'd0, mode}, 8'd1);
    wakeAll();
    // R5 wfe beats isr: rule is event, irq does not wake
    sleepOnExit = 1;
    wfeReq = 1; isrReturn = 1;
    tick();
    wfeReq = 0; isrReturn = 0; sleepOnExit = 0;
    irqPending = 1;
    tick();
    irqPending = 0;
    check("R5 wfe over isr", {6'd0, mode}, 8'd1);
    wakeAll();
    check("R5 back to run", {6'd0, mode}, 8'd0);

    // R10 stop with flash power-down and low-power regulator
    deepSleep = 1; flashPdEn = 1; regLpSel = 1; wfiReq = 1;
    tick();
    wfiReq = 0; deepSleep = 0; flashPdEn = 0; regLpSel = 0;
    check("R10 stop mode", {6'd0, mode}, 8'd2);
    check("R10 stop gates", {4'd0, coreClkEn, domainClkEn, pllEn, oscEn}, 8'h0);
    check("R10 flashPd/regLp latched", {6'd0, flashPd, regLowPower}, 8'h3);
    irqPending = 1;
    tick();
    irqPending = 0;
    // R11 oscillator restart
    check("R11 osc/pll on", {6'd0, pllEn, oscEn}, 8'h3);
    check("R11 regulator normal", {7'd0, regLowPower}, 8'd0);
    check("R11 still gated", {6'd0, coreClkEn, domainClkEn}, 8'd0);
    oscReady = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R11 wait regReady", {6'd0, mode}, 8'd2);
    end
    regReady = 1;
    tick();
    oscReady = 0; regReady = 0;
    // R12 flash delay
    check("R12 flashPd cleared", {7'd0, flashPd}, 8'd0);
    check("R12 core held", {7'd0, coreClkEn}, 8'd0);
    for (int k = 1; k < FD; k++) begin
      tick();
      check($sformatf("R12 core held cycle %0d", k), {7'd0, coreClkEn}, 8'd0);
    end
    tick();
    check("R12 core released", {7'd0, coreClkEn}, 8'd1);
    check("R12 run mode", {6'd0, mode}, 8'd0);

    // R10 stop without flash power-down, entered by wfe
    deepSleep = 1; wfeReq = 1;
    tick();
    wfeReq = 0; deepSleep = 0;
    check("R10 stop no flashPd", {6'd0, flashPd, regLowPower}, 8'd0);
    irqPending = 1; irqPendingAny = 1;
    tick();
    irqPending = 0; irqPendingAny = 0;
    check("R7 stop ignores irq", {7'd0, oscEn}, 8'd0);
    wakeEvent = 1;
    tick();
    wakeEvent = 0;
    check("R11 event leaves stop", {7'd0, oscEn}, 8'd1);
    oscReady = 1; regReady = 1;
    tick();
    oscReady = 0; regReady = 0;
    check("R12 release without delay", {7'd0, coreClkEn}, 8'd1);
    check("R12 domain clock back", {7'd0, domainClkEn}, 8'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule